// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block behaves as a byte-addressed non-volatile memory that answers on a two-wire I2C bus at one fixed 7-bit device address. The host writes by sending the device address with the direction bit clear, then a 16-bit memory address (high byte first), then data bytes. Incoming data bytes are collected in a page buffer. When the host issues STOP, a timed internal write cycle begins and the collected bytes are copied into the array. While that cycle runs, the device does not acknowledge its own address, so the host can poll until the device answers again.

A read first sends the memory address through a short write with no data, then a repeated START with the direction bit set. Bytes then stream out from the pointer until the host answers a byte with NACK and sends STOP. SCL and SDA are oversampled with the system clock. SDA is driven open-drain: the output is an enable that pulls the line low. A write-protect input makes the array read-only. The array size, page size, device address and write-cycle length are parameters. The default of 2048 bytes keeps elaboration light, and the same logic scales to a 32 KiB array of 512 pages of 64 bytes.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The device acknowledges an address byte only when its upper seven bits equal DEV_ADDR (default 7'h50). On a mismatch it acknowledges neither that byte nor any later byte until the next START.
- R2: Every address byte and every data byte that the device accepts is acknowledged by driving sda_oe_o high (SDA low) for the whole high phase of the ninth SCL pulse.
- R3: After an address byte with bit 0 = 0, the next two bytes load the pointer, high byte first. Pointer bits at or above log2(MEM_BYTES) are discarded. The data bytes that follow are written from that pointer.
- R4: During a write, only the low log2(PAGE_BYTES) bits of the pointer advance. Bytes past the end of a page land at the start of the same page, and no other page changes.
- R5: A write cycle starts only at STOP and only if at least one data byte was stored. It lasts WR_CYCLES clock cycles whether one byte or a full page was sent. Stored bytes followed by a repeated START, with no STOP, are discarded.
- R6: While the write cycle is in progress, the device NACKs its own address.
- R7: While wp_i is high, data bytes are still acknowledged but are not stored, the array keeps its contents, and no write cycle starts.
- R8: A write of the memory address with no data, followed by a repeated START and an address byte with bit 0 = 1, returns the byte at that address first. The device drives each bit MSB first while SCL is low.
- R9: During a read, the pointer advances after every byte sent and wraps from the last address to zero. A host NACK ends the read: the device releases SDA and drives no further bits.
- R10: After reset, SDA is released, no write cycle is pending, and the device acknowledges its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| wp_i | input | 1 | Write protect; high makes the array read-only |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |

## Verification
A bus event takes effect at the control logic three clock cycles after a line edge: two synchronizer stages and one history stage. The registered SDA enable then changes one cycle later, so the device changes SDA about four cycles after each SCL fall. The bench holds every SCL phase for eight clock cycles and samples SDA only at the end of an SCL high phase, well after any change the device could make. The write cycle is timed in whole polling transactions. The bench records the cycle when STOP completes and the cycle when the first poll is acknowledged, and checks that the gap is at least WR_CYCLES less one phase and at most WR_CYCLES plus a few polls.

// File: rtl/eep_pkg.sv
package eep_pkg;

  // Protocol phase of the slave
  typedef enum logic [2:0] {
    ST_IDLE,   // not addressed, waiting for START
    ST_DEV,    // receiving the device address byte
    ST_AHI,    // receiving the high memory address byte
    ST_ALO,    // receiving the low memory address byte
    ST_WR,     // receiving data bytes for the page buffer
    ST_RD      // transmitting data bytes
  } eep_state_e;

  // Bus events derived from the oversampled lines
  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } eep_bus_ev_t;

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync
  import eep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output eep_bus_ev_t ev
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  // Idle bus is high on both lines
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  always_comb begin
    ev.scl_rise = scl_s & ~scl_q;
    ev.scl_fall = ~scl_s & scl_q;
    ev.start    = scl_s & scl_q & sda_q & ~sda_s;
    ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    ev.sda      = sda_s;
  end

endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] cells [DEPTH];

  // Single-port, read-first, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    rdata <= cells[addr];
  end

endmodule

// File: rtl/eep_write_ctl.sv
module eep_write_ctl #(
  parameter int PAGE_BYTES = 64,
  parameter int AW         = 11,
  parameter int WR_CYCLES  = 625000,
  localparam int PW        = $clog2(PAGE_BYTES),
  localparam int TW        = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             buf_we,
  input  logic [PW-1:0]    buf_idx,
  input  logic [7:0]       buf_wdata,
  input  logic             buf_clear,
  input  logic             commit_req,
  input  logic [AW-PW-1:0] page_base,
  output logic             busy,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata
);

  logic [7:0]            page_ram [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;
  logic [TW-1:0]         tmr;
  logic [PW-1:0]         cidx, rd_idx;
  logic                  sweep, rd_go, rd_v;
  logic [7:0]            rd_d;
  logic [AW-PW-1:0]      base_q;

  // Page buffer storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (buf_we) page_ram[buf_idx] <= buf_wdata;
    rd_d <= page_ram[cidx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      tmr    <= '0;
      cidx   <= '0;
      sweep  <= 1'b0;
      rd_go  <= 1'b0;
      rd_v   <= 1'b0;
      rd_idx <= '0;
      vld    <= '0;
      base_q <= '0;
    end else begin
      rd_go  <= sweep;
      rd_v   <= vld[cidx];
      rd_idx <= cidx;
      if (buf_we) vld[buf_idx] <= 1'b1;
      if (!busy) begin
        if (commit_req && |vld) begin
          busy   <= 1'b1;
          tmr    <= '0;
          cidx   <= '0;
          sweep  <= 1'b1;
          base_q <= page_base;
        end else if (buf_clear) begin
          vld <= '0;
        end
      end else begin
        tmr <= tmr + 1'b1;
        if (sweep) begin
          cidx <= cidx + 1'b1;
          if (cidx == PW'(PAGE_BYTES - 1)) sweep <= 1'b0;
        end
        if (tmr == TW'(WR_CYCLES - 1)) begin
          busy <= 1'b0;
          vld  <= '0;
        end
      end
    end
  end

  // Copy stage: one buffered byte per cycle into the array
  assign mem_we    = rd_go & rd_v;
  assign mem_addr  = {base_q, rd_idx};
  assign mem_wdata = rd_d;

  // Independent age counter for the busy window
  logic [TW-1:0] busy_age;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_age <= '0;
    else              busy_age <= busy_age + 1'b1;
  end

  p_busy_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(busy_age) == TW'(WR_CYCLES - 1));

  p_we_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  p_empty_no_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (commit_req && !busy && vld == '0) |=> !busy);

endmodule

// File: rtl/eep_proto.sv
module eep_proto
  import eep_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int AW = 11,
  parameter int PW = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  eep_bus_ev_t      ev,
  input  logic             busy,
  input  logic             wp_i,
  input  logic [7:0]       rdata,
  output logic             sda_oe,
  output logic [AW-1:0]    ptr,
  output logic             buf_we,
  output logic [PW-1:0]    buf_idx,
  output logic [7:0]       buf_wdata,
  output logic             buf_clear,
  output logic             commit_req,
  output logic [AW-PW-1:0] page_base
);

  eep_state_e    st;
  logic [3:0]    cnt;
  logic          ack_ph;
  logic [7:0]    shreg, txsh;
  logic [AW-9:0] hi_q;

  assign page_base = ptr[AW-1:PW];

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      ack_ph     <= 1'b0;
      shreg      <= '0;
      txsh       <= '0;
      hi_q       <= '0;
      ptr        <= '0;
      sda_oe     <= 1'b0;
      buf_we     <= 1'b0;
      buf_idx    <= '0;
      buf_wdata  <= '0;
      buf_clear  <= 1'b0;
      commit_req <= 1'b0;
    end else begin
      buf_we     <= 1'b0;
      buf_clear  <= 1'b0;
      commit_req <= 1'b0;
      if (ev.start) begin
        st        <= ST_DEV;
        cnt       <= '0;
        ack_ph    <= 1'b0;
        sda_oe    <= 1'b0;
        buf_clear <= 1'b1;
      end else if (ev.stop) begin
        if (st == ST_WR) commit_req <= 1'b1;
        st     <= ST_IDLE;
        cnt    <= '0;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else if (st == ST_RD) begin
        if (ev.scl_rise) begin
          if (ack_ph) begin
            if (ev.sda) st <= ST_IDLE;   // host NACK ends the read
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (ev.scl_fall) begin
          if (ack_ph) begin
            ack_ph <= 1'b0;
            cnt    <= '0;
            txsh   <= rdata;
            sda_oe <= ~rdata[7];
          end else if (cnt == 4'd8) begin
            ack_ph <= 1'b1;
            sda_oe <= 1'b0;
            ptr    <= ptr + 1'b1;
          end else begin
            sda_oe <= ~txsh[3'(4'd7 - cnt)];
          end
        end
      end else if (st != ST_IDLE) begin
        if (ev.scl_rise && !ack_ph) begin
          shreg <= {shreg[6:0], ev.sda};
          cnt   <= cnt + 1'b1;
        end else if (ev.scl_fall) begin
          if (ack_ph) begin
            ack_ph <= 1'b0;
            cnt    <= '0;
            sda_oe <= 1'b0;
          end else if (cnt == 4'd8) begin
            unique case (st)
              ST_DEV: begin
                if (shreg[7:1] == DEV_ADDR && !busy) begin
                  ack_ph <= 1'b1;
                  sda_oe <= 1'b1;
                  st     <= shreg[0] ? ST_RD : ST_AHI;
                end else begin
                  st <= ST_IDLE;
                end
              end
              ST_AHI: begin
                hi_q   <= shreg[AW-9:0];
                ack_ph <= 1'b1;
                sda_oe <= 1'b1;
                st     <= ST_ALO;
              end
              ST_ALO: begin
                ptr       <= {hi_q, shreg};
                ack_ph    <= 1'b1;
                sda_oe    <= 1'b1;
                buf_clear <= 1'b1;
                st        <= ST_WR;
              end
              ST_WR: begin
                ack_ph <= 1'b1;
                sda_oe <= 1'b1;
                if (!wp_i) begin
                  buf_we    <= 1'b1;
                  buf_idx   <= ptr[PW-1:0];
                  buf_wdata <= shreg;
                end
                ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  // SDA only moves right after an SCL fall or a bus condition
  p_oe_after_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(ev.scl_fall || ev.start || ev.stop));

  p_nack_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DEV && busy && ev.scl_fall && !ack_ph && cnt == 4'd8 && !ev.start && !ev.stop)
    |=> !sda_oe);

  p_page_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR && $past(st) == ST_WR) |-> $stable(ptr[AW-1:PW]));

  p_wp_no_store_r7: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> !$past(wp_i));

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eep_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         MEM_BYTES   = 2048,
  parameter int         PAGE_BYTES  = 64,
  parameter int         WR_CYCLES   = 625000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  eep_bus_ev_t      ev;
  logic             busy;
  logic [AW-1:0]    ptr;
  logic             buf_we, buf_clear, commit_req;
  logic [PW-1:0]    buf_idx;
  logic [7:0]       buf_wdata;
  logic [AW-PW-1:0] page_base;
  logic             mem_we;
  logic [AW-1:0]    mem_addr, arr_addr;
  logic [7:0]       mem_wdata, rdata;

  eep_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
  );

  eep_proto #(.DEV_ADDR(DEV_ADDR), .AW(AW), .PW(PW)) u_proto (
    .clk(clk), .rst(rst), .ev(ev), .busy(busy), .wp_i(wp_i), .rdata(rdata),
    .sda_oe(sda_oe_o), .ptr(ptr), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_wdata(buf_wdata), .buf_clear(buf_clear), .commit_req(commit_req),
    .page_base(page_base)
  );

  eep_write_ctl #(.PAGE_BYTES(PAGE_BYTES), .AW(AW), .WR_CYCLES(WR_CYCLES)) u_wctl (
    .clk(clk), .rst(rst), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_wdata(buf_wdata), .buf_clear(buf_clear), .commit_req(commit_req),
    .page_base(page_base), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // The array is owned by the copy engine during a write cycle
  assign arr_addr = busy ? mem_addr : ptr;

  eep_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_array (
    .clk(clk), .we(mem_we), .addr(arr_addr), .wdata(mem_wdata), .rdata(rdata)
  );

endmodule

// File: tb/test_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module test_i2c_eeprom_slave;

  localparam logic [6:0] DEV  = 7'h50;
  localparam int MEM   = 2048;
  localparam int WR_T  = 600;
  localparam int H     = 8;
  localparam logic [15:0] AMASK = 16'(MEM - 1);

  // {address[15:0], data[7:0]}
  localparam logic [23:0] VEC [6] = '{
    24'h0000A5, 24'h00103C, 24'h008077, 24'h07FFE1, 24'hF8055A, 24'h0123C3
  };

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;
  int   cyc = 0, nvec = 0, nfail = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_eeprom_slave #(.DEV_ADDR(DEV), .MEM_BYTES(MEM), .PAGE_BYTES(64), .WR_CYCLES(WR_T))
    i_i2c_eeprom_slave (.clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
                        .wp_i(wp), .sda_oe_o(sda_oe));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(H);
    end
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    ack = ~sda_bus;
    scl_m = 1'b0; tick(H);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl_m = 1'b1; tick(H); b[i] = sda_bus; scl_m = 1'b0;
    end
    tick(H); sda_m = ~give_ack; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(H);
    sda_m = 1'b1;
  endtask

  task automatic poll_once(output logic ack);
    bus_start(); send_byte({DEV, 1'b0}, ack); bus_stop();
  endtask

  task automatic wait_ready(output int t_ack);
    logic a;
    int n;
    n = 0;
    do begin poll_once(a); n++; end while (!a && n < 100);
    t_ack = cyc;
  endtask

  task automatic do_write(input logic [15:0] a, input int n, output logic allack);
    logic k;
    allack = 1'b1;
    bus_start();
    send_byte({DEV, 1'b0}, k); allack &= k;
    send_byte(a[15:8], k);     allack &= k;
    send_byte(a[7:0], k);      allack &= k;
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], k); allack &= k; end
    bus_stop();
  endtask

  task automatic do_read(input logic [15:0] a, input int n);
    logic k;
    bus_start();
    send_byte({DEV, 1'b0}, k); send_byte(a[15:8], k); send_byte(a[7:0], k);
    bus_start();
    send_byte({DEV, 1'b1}, k);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic ok, k;
    int t0, t1;
    tick(5); rst = 1'b0; tick(4);

    // R10: released SDA and ready after reset
    chk("R10 sda released", 32'(sda_oe), 0);
    poll_once(k);
    chk("R10 ack after reset", 32'(k), 1);

    // R3/R8/R2: table of single-byte writes, each read back
    for (int v = 0; v < 6; v++) begin
      wbuf[0] = VEC[v][7:0];
      do_write(VEC[v][23:8], 1, ok);
      chk("R2 all bytes acked", 32'(ok), 1);
      wait_ready(t1);
      do_read(VEC[v][23:8] & AMASK, 1);
      chk("R3 R8 readback", 32'(rbuf[0]), 32'(VEC[v][7:0]));
    end

    // R1: foreign address is ignored until next START
    bus_start();
    send_byte({7'h51, 1'b0}, k);
    chk("R1 foreign address nack", 32'(k), 0);
    send_byte(8'h00, k);
    chk("R1 following byte nack", 32'(k), 0);
    bus_stop();

    // R5/R6: single-byte write cycle length and NACK while busy
    wbuf[0] = 8'h42;
    do_write(16'h0200, 1, ok);
    t0 = cyc;
    poll_once(k);
    chk("R6 nack during write cycle", 32'(k), 0);
    wait_ready(t1);
    chk("R5 one-byte cycle not short", 32'(t1 - t0 >= WR_T - H), 1);
    chk("R5 one-byte cycle not long", 32'(t1 - t0 <= WR_T + 700), 1);

    // R4: six bytes from 0x7C wrap to the start of page 0x40
    for (int i = 0; i < 6; i++) wbuf[i] = 8'h10 + 8'(i);
    do_write(16'h007C, 6, ok);
    t0 = cyc;
    wait_ready(t1);
    chk("R5 page cycle not short", 32'(t1 - t0 >= WR_T - H), 1);
    chk("R5 page cycle not long", 32'(t1 - t0 <= WR_T + 700), 1);
    do_read(16'h007C, 4);
    for (int i = 0; i < 4; i++) chk("R4 page tail", 32'(rbuf[i]), 32'h10 + i);
    do_read(16'h0040, 2);
    chk("R4 wrapped byte 0", 32'(rbuf[0]), 32'h14);
    chk("R4 wrapped byte 1", 32'(rbuf[1]), 32'h15);
    do_read(16'h0080, 1);
    chk("R4 next page untouched", 32'(rbuf[0]), 32'h77);

    // R7: protected write is acked, not stored, no cycle
    wp = 1'b1;
    wbuf[0] = 8'hEE;
    do_write(16'h0010, 1, ok);
    chk("R7 protected bytes acked", 32'(ok), 1);
    poll_once(k);
    chk("R7 no write cycle", 32'(k), 1);
    wp = 1'b0;
    do_read(16'h0010, 1);
    chk("R7 array unchanged", 32'(rbuf[0]), 32'h3C);

    // R9: sequential read wraps to zero; nothing after host NACK
    do_read(16'h07FF, 2);
    chk("R9 last address", 32'(rbuf[0]), 32'hE1);
    chk("R9 wrap to zero", 32'(rbuf[1]), 32'hA5);
    bus_start();
    send_byte({DEV, 1'b0}, k); send_byte(8'h00, k); send_byte(8'h10, k);
    bus_start();
    send_byte({DEV, 1'b1}, k);
    recv_byte(1'b0, rbuf[0]);
    recv_byte(1'b1, rbuf[1]);
    chk("R9 single byte then nack", 32'(rbuf[0]), 32'h3C);
    chk("R9 bus released after nack", 32'(rbuf[1]), 32'hFF);
    bus_stop();

    // R5: data followed by repeated START is discarded
    wbuf[0] = 8'h11;
    do_write(16'h0300, 1, ok);
    wait_ready(t1);
    bus_start();
    send_byte({DEV, 1'b0}, k); send_byte(8'h03, k); send_byte(8'h00, k);
    send_byte(8'h99, k);
    bus_start();
    send_byte({DEV, 1'b1}, k);
    chk("R5 repeated start keeps device free", 32'(k), 1);
    recv_byte(1'b0, rbuf[0]);
    bus_stop();
    poll_once(k);
    chk("R5 no cycle without stop", 32'(k), 1);
    do_read(16'h0300, 1);
    chk("R5 discarded data", 32'(rbuf[0]), 32'h11);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule